// File: doc/BRIEF.md
# Latched-Reload Watchdog Timer

This block is a 16-bit watchdog that supervises software by counting clock cycles down from a timeout. It starts disarmed after any reset. Software arms it by writing a nonzero timeout through a simple write strobe with data. That first value is stored. From then on, every write reloads the counter from the stored value, whatever data is on the bus. If software stops writing and the count runs out, the block raises a one-cycle request for a full reset of the core and its peripherals.

An expiry also sets a sticky cause flag. The flag is meant to sit at bit 1 of the system status word. It survives the reset that the watchdog itself requested, so software that comes back up can tell a watchdog restart from an external one. While the block is disarmed, a write of zero clears the flag and leaves the timer disarmed. The external (power-on) reset input clears the whole block, flag included, and never sets the flag. An expiry returns the block to the disarmed state and discards the stored timeout, so the next write supplies a new one.

A write that lands on the same edge as the final count wins: the counter reloads and no expiry occurs.

Top module: `wdt_core`

## Requirements
- R1: After the external reset is released, `wd_rst_req` and `wd_cause` are 0, and with no writes `wd_rst_req` never pulses.
- R2: A nonzero write while disarmed arms the timer with that value N (1 to 65535). If there are no further writes, `wd_rst_req` is 1 for the cycle that begins at the N-th rising edge after the write edge.
- R3: While armed, every write (data zero or not) restarts the count from the value stored by the arming write, and the data on the bus is ignored.
- R4: `wd_rst_req` lasts exactly one cycle. After an expiry the timer is disarmed and the stored value is discarded, so the next nonzero write sets a new timeout.
- R5: An expiry sets `wd_cause` (status bit 1) in the same cycle as the request. The flag stays set through the expiry and through later arming or reload writes.
- R6: A zero write while disarmed clears `wd_cause` and leaves the timer disarmed, so no request follows.
- R7: A write on the edge where the count would reach zero suppresses that expiry and reloads the stored value.
- R8: Asserting `por_rst_n` low disarms the timer, clears the count and clears `wd_cause`. It never sets `wd_cause`.
- R9: Writes spaced more closely than the stored timeout keep `wd_rst_req` low indefinitely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock |
| por_rst_n | input | 1 | Asynchronous active-low external/power-on reset |
| wr_en | input | 1 | Write strobe for the timeout register |
| wr_data | input | 16 | Write data for the timeout register |
| wd_rst_req | output | 1 | One-cycle full-reset request on expiry |
| wd_cause | output | 1 | Sticky watchdog-cause flag (status bit 1) |

## Verification
The assertions assume that `wr_en` and `wr_data` are synchronous to `clk` and are stable around the rising edge. They also assume that the request output is not fed back into `por_rst_n`, so the cause flag can be observed across an expiry. The bench drives every write at the falling edge and holds the strobe for exactly one rising edge. It places the write that must collide with the final count by its own cycle counter, one falling edge before the computed deadline. It applies the external reset only while the strobe is low.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

   // Decoded meaning of one cycle on the write port.
   typedef enum logic [1:0] {
      WDT_OP_NONE   = 2'd0,
      WDT_OP_ARM    = 2'd1,
      WDT_OP_RELOAD = 2'd2,
      WDT_OP_CLEAR  = 2'd3
   } wdt_op_e;

   // Bit of the system status word that carries the watchdog cause flag.
   localparam int unsigned WDT_CAUSE_BIT = 1;

   // A write is an arm while disarmed with nonzero data, a cause clear
   // while disarmed with zero data, and a reload whenever armed.
   function automatic wdt_op_e wdt_decode(input logic wr,
                                          input logic armed,
                                          input logic data_zero);
      wdt_op_e op;
      if (!wr)
         op = WDT_OP_NONE;
      else if (armed)
         op = WDT_OP_RELOAD;
      else if (data_zero)
         op = WDT_OP_CLEAR;
      else
         op = WDT_OP_ARM;
      return op;
   endfunction

endpackage

// File: rtl/wdt_arm_ctrl.sv
module wdt_arm_ctrl
   import wdt_pkg::*;
#(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  wdt_op_e      op,
   input  logic [W-1:0] wr_data,
   input  logic         expire,
   output logic         armed,
   output logic [W-1:0] captured
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed    <= 1'b0;
         captured <= '0;
      end else if (expire) begin
         // Expiry drops back to disarmed and forgets the timeout.
         armed    <= 1'b0;
         captured <= '0;
      end else if (op == WDT_OP_ARM) begin
         armed    <= 1'b1;
         captured <= wr_data;
      end
   end

endmodule

// File: rtl/wdt_down_counter.sv
module wdt_down_counter #(
   parameter int unsigned W         = 16,
   parameter bit          LOOKAHEAD = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         run,
   input  logic         clr,
   output logic [W-1:0] count,
   output logic         at_one
);

   localparam logic [W-1:0] ONE = W'(1);

   logic [W-1:0] count_q;
   logic [W-1:0] count_d;

   always_comb begin
      count_d = count_q;
      if (load)
         count_d = load_val;
      else if (clr)
         count_d = '0;
      else if (run && (count_q != '0))
         count_d = count_q - ONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         count_q <= '0;
      else
         count_q <= count_d;
   end

   assign count = count_q;

   generate
      if (LOOKAHEAD) begin : g_lookahead
         // Terminal flag precomputed one cycle ahead from the next count.
         logic at_one_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               at_one_q <= 1'b0;
            else
               at_one_q <= (count_d == ONE);
         end
         assign at_one = at_one_q;
      end else begin : g_compare
         assign at_one = (count_q == ONE);
      end
   endgenerate

endmodule

// File: rtl/wdt_cause_flag.sv
module wdt_cause_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic cause
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cause <= 1'b0;
      else if (set)
         cause <= 1'b1;
      else if (clr)
         cause <= 1'b0;
   end

endmodule

// File: rtl/wdt_core.sv
module wdt_core
   import wdt_pkg::*;
#(
   parameter int unsigned TMR_W     = 16,
   parameter bit          LOOKAHEAD = 1'b0
) (
   input  logic             clk,
   input  logic             por_rst_n,
   input  logic             wr_en,
   input  logic [TMR_W-1:0] wr_data,
   output logic             wd_rst_req,
   output logic             wd_cause
);

   generate
      if (TMR_W < 2 || TMR_W > 32) begin : g_bad_width
         $error("wdt_core: TMR_W must lie in 2..32");
      end
   endgenerate

   wdt_op_e          op;
   logic             armed;
   logic [TMR_W-1:0] captured;
   logic [TMR_W-1:0] count;
   logic             at_one;
   logic             load;
   logic [TMR_W-1:0] load_val;
   logic             expire;
   logic             req_q;

   assign op       = wdt_decode(wr_en, armed, (wr_data == '0));
   assign load     = (op == WDT_OP_ARM) || (op == WDT_OP_RELOAD);
   assign load_val = (op == WDT_OP_ARM) ? wr_data : captured;
   // A write on the terminal edge wins over expiry.
   assign expire   = armed && !wr_en && at_one;

   wdt_arm_ctrl #(.W(TMR_W)) u_arm (
      .clk      (clk),
      .rst_n    (por_rst_n),
      .op       (op),
      .wr_data  (wr_data),
      .expire   (expire),
      .armed    (armed),
      .captured (captured)
   );

   wdt_down_counter #(.W(TMR_W), .LOOKAHEAD(LOOKAHEAD)) u_cnt (
      .clk      (clk),
      .rst_n    (por_rst_n),
      .load     (load),
      .load_val (load_val),
      .run      (armed),
      .clr      (expire),
      .count    (count),
      .at_one   (at_one)
   );

   wdt_cause_flag u_cause (
      .clk   (clk),
      .rst_n (por_rst_n),
      .set   (expire),
      .clr   (op == WDT_OP_CLEAR),
      .cause (wd_cause)
   );

   always_ff @(posedge clk or negedge por_rst_n) begin
      if (!por_rst_n)
         req_q <= 1'b0;
      else
         req_q <= expire;
   end

   assign wd_rst_req = req_q;

endmodule

// File: rtl/wdt_core_chk.sv
module wdt_core_chk #(
   parameter int unsigned W = 16
) (
   input logic         clk,
   input logic         rst_n,
   input logic         wr_en,
   input logic [W-1:0] wr_data,
   input logic         armed,
   input logic [W-1:0] captured,
   input logic [W-1:0] count,
   input logic         req,
   input logic         cause
);

   always @(posedge clk) begin
      if (!rst_n) begin
         assert_reset_clears_R8: assert (!req && !cause && !armed && count == '0)
            else $error("R8: reset did not clear the watchdog");
      end
   end

   assert_no_req_disarmed_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !armed |=> !req);

   assert_first_write_arms_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!armed && wr_en && wr_data != '0) |=> (armed && count == $past(wr_data)));

   assert_reload_stored_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && wr_en) |=> (armed && count == $past(captured)));

   assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      req |=> !req);

   assert_expiry_sets_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !wr_en && count == W'(1)) |=> (req && cause && !armed));

   assert_cause_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cause && !(wr_en && !armed && wr_data == '0)) |=> cause);

   assert_zero_write_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!armed && wr_en && wr_data == '0) |=> (!cause && !armed));

   assert_write_beats_expiry_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && wr_en) |=> !req);

endmodule

bind wdt_core wdt_core_chk #(.W(TMR_W)) u_chk (
   .clk      (clk),
   .rst_n    (por_rst_n),
   .wr_en    (wr_en),
   .wr_data  (wr_data),
   .armed    (armed),
   .captured (captured),
   .count    (count),
   .req      (wd_rst_req),
   .cause    (wd_cause)
);

// File: tb/wdt_core_tb.sv
module wdt_core_tb;
   localparam int W = 16;

   logic         clk = 1'b0;
   logic         por_rst_n = 1'b0;
   logic         wr_en = 1'b0;
   logic [W-1:0] wr_data = '0;
   logic         wd_rst_req;
   logic         wd_cause;

   always #5 clk = ~clk;

   wdt_core u_dut (
      .clk        (clk),
      .por_rst_n  (por_rst_n),
      .wr_en      (wr_en),
      .wr_data    (wr_data),
      .wd_rst_req (wd_rst_req),
      .wd_cause   (wd_cause)
   );

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int checks = 0;
   int fails  = 0;
   int pulses = 0;
   int exp_q[$];
   bit m_armed = 1'b0;
   int m_cap   = 0;
   bit m_cause = 1'b0;
   bit done    = 1'b0;

   task automatic check(input bit ok, input string tag, input int act, input int expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, expv, cyc);
      end
   endtask

   // Monitor: pops expected expiry cycles and compares with observed pulses.
   always @(negedge clk) begin
      if (por_rst_n && !done) begin
         if (wd_rst_req) begin
            pulses++;
            if (exp_q.size() != 0 && exp_q[0] == cyc) begin
               checks++;
               void'(exp_q.pop_front());
               m_armed = 1'b0;
               m_cause = 1'b1;
            end else begin
               check(1'b0, "R2 R4 pulse cycle", cyc,
                     (exp_q.size() != 0) ? exp_q[0] : -1);
            end
         end else if (exp_q.size() != 0 && exp_q[0] <= cyc) begin
            check(1'b0, "R2 missing pulse", cyc, exp_q[0]);
            void'(exp_q.pop_front());
            m_armed = 1'b0;
            m_cause = 1'b1;
         end
      end
   end

   // Driver: one write, expected deadline pushed from the requirement model.
   task automatic wr(input logic [W-1:0] d);
      wr_en   = 1'b1;
      wr_data = d;
      @(posedge clk);
      #1;
      if (!m_armed) begin
         if (d != '0) begin
            m_armed = 1'b1;
            m_cap   = int'(d);
            exp_q.push_back(cyc + int'(d));
         end else begin
            m_cause = 1'b0;
         end
      end else begin
         exp_q.delete();
         exp_q.push_back(cyc + m_cap);
      end
      @(negedge clk);
      wr_en   = 1'b0;
      wr_data = '0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset();
      por_rst_n = 1'b0;
      exp_q.delete();
      m_armed = 1'b0;
      m_cap   = 0;
      m_cause = 1'b0;
      idle(3);
      por_rst_n = 1'b1;
      idle(1);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired before the end of the test");
      summary();
      $finish;
   end

   initial begin
      int p0;
      int t0;
      idle(3);
      por_rst_n = 1'b1;
      idle(1);
      // R1: reset state and silence while disarmed
      check(wd_rst_req == 1'b0, "R1 req after reset", wd_rst_req, 0);
      check(wd_cause == 1'b0, "R1 cause after reset", wd_cause, 0);
      p0 = pulses;
      idle(300);
      check(pulses == p0, "R1 no pulse while disarmed", pulses, p0);

      // R2: arm with 20, expiry 20 cycles later; R5 cause set
      p0 = pulses;
      wr(16'd20);
      idle(25);
      check(pulses == p0 + 1, "R2 expiry after 20", pulses, p0 + 1);
      check(wd_cause == 1'b1, "R5 cause set by expiry", wd_cause, 1);

      // R4: stored value discarded, new write of 7 is the new timeout
      p0 = pulses;
      wr(16'd7);
      idle(10);
      check(pulses == p0 + 1, "R4 new timeout after expiry", pulses, p0 + 1);
      check(wd_cause == 1'b1, "R5 cause sticky across re-arm", wd_cause, 1);

      // R6: zero write while disarmed clears cause, stays disarmed
      p0 = pulses;
      wr(16'd0);
      check(wd_cause == 1'b0, "R6 zero write clears cause", wd_cause, 0);
      idle(100);
      check(pulses == p0, "R6 zero write does not arm", pulses, p0);
      wr(16'd0);
      idle(100);
      check(pulses == p0 && wd_cause == 1'b0, "R6 repeat zero write inert", pulses, p0);

      // R3: later writes ignore data (300, then 0) and reload 15
      p0 = pulses;
      wr(16'd15);
      idle(9);
      wr(16'd300);
      idle(9);
      wr(16'd0);
      idle(9);
      check(pulses == p0, "R3 reload keeps timer alive", pulses, p0);
      idle(10);
      check(pulses == p0 + 1, "R3 expiry uses stored 15", pulses, p0 + 1);

      // R7: write on the terminal edge suppresses expiry
      p0 = pulses;
      wr(16'd12);
      t0 = cyc;
      while (cyc < t0 + 11) @(negedge clk);
      wr(16'd5);
      idle(2);
      check(pulses == p0, "R7 collision write suppresses expiry", pulses, p0);
      idle(15);
      check(pulses == p0 + 1, "R7 reloaded count expires later", pulses, p0 + 1);

      // R2: smallest timeout
      p0 = pulses;
      wr(16'd1);
      idle(3);
      check(pulses == p0 + 1, "R2 timeout of one cycle", pulses, p0 + 1);

      // R9: servicing every 30 cycles with a 40-cycle timeout
      p0 = pulses;
      wr(16'd40);
      for (int i = 0; i < 10; i++) begin
         idle(29);
         wr(16'd0);
      end
      check(pulses == p0, "R9 regular service prevents expiry", pulses, p0);
      idle(45);
      check(pulses == p0 + 1, "R9 expiry once service stops", pulses, p0 + 1);

      // R8: external reset mid-count clears cause and timer
      p0 = pulses;
      wr(16'd50);
      idle(20);
      do_reset();
      check(wd_cause == 1'b0, "R8 reset clears cause", wd_cause, 0);
      idle(100);
      check(pulses == p0 && wd_cause == 1'b0, "R8 reset disarms", pulses, p0);
      wr(16'd9);
      idle(12);
      check(pulses == p0 + 1, "R8 fresh timeout after reset", pulses, p0 + 1);

      // R2: largest timeout
      p0 = pulses;
      wr(16'hFFFF);
      idle(65530);
      check(pulses == p0, "R2 no early expiry at 65535", pulses, p0);
      idle(10);
      check(pulses == p0 + 1, "R2 expiry at 65535", pulses, p0 + 1);
      check(exp_q.size() == 0, "R2 no pending expiry", exp_q.size(), 0);

      done = 1'b1;
      summary();
      $finish;
   end

endmodule